// File: doc/BRIEF.md
# Parallel Byte Table Lookup Unit

The unit translates a vector of eight byte indices through a small byte table. Each index picks one byte out of a table of one to four 64-bit words, and the chosen byte goes to the lane of the result that matches the index's own lane. The table words, the index vector, the current destination vector and a policy bit arrive together on the input ports with a one-cycle valid strobe. One clock later the translated vector appears on a registered output, marked by a one-cycle valid pulse.

The policy bit sets what happens to a lane whose index points past the end of the table. In zeroing policy such a lane becomes 0x00. In keep policy the lane takes its value from the destination vector that was supplied, so a long table can be looked up in pieces: each later piece fills only the lanes that earlier pieces left untouched. Each lane checks its index against the table length by itself, and the table length can change on every request.

Top module: `byte_table_lookup_unit`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first accepted request, `res_valid` is 0 and `res_data` is all zeros.
- R2: A request with `req_valid` high at a rising clock edge produces `res_valid` high for exactly the next cycle. `res_valid` is low in any cycle that follows an edge at which `req_valid` was low.
- R3: Lane i of the index vector is `req_idx[8i+7:8i]`. Lane i of the result is `res_data[8i+7:8i]`. Each result lane depends only on its own index lane, its own destination lane, the table, the word count and the policy bit.
- R4: Table byte k is `req_table[8k+7:8k]`, with word 0 in bits [63:0] and word 3 in bits [255:192]. The number of words present is `req_words_m1 + 1`, where `req_words_m1` ranges 0 to 3.
- R5: A lane whose index, read as unsigned, is at most 8 × (words present) − 1 receives table byte k = index under either policy. Table bytes at or above 8 × (words present) never reach the result.
- R6: With `req_keep` = 0 (zeroing policy), a lane whose index exceeds 8 × (words present) − 1 yields 0x00.
- R7: With `req_keep` = 1 (keep policy), a lane whose index exceeds 8 × (words present) − 1 yields the matching byte of `req_dest`.
- R8: Indices 32 to 255 are out of range for every word count.
- R9: `res_data` keeps its value in every cycle that follows an edge at which `req_valid` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| req_valid | input | 1 | Request strobe, one cycle per lookup |
| req_keep | input | 1 | Out-of-range policy: 0 forces zero, 1 keeps the destination lane |
| req_words_m1 | input | 2 | Number of table words present, minus one |
| req_table | input | 256 | Table words, word 0 in the low 64 bits |
| req_idx | input | 64 | Eight byte indices, lane 0 in the low byte |
| req_dest | input | 64 | Current destination vector, used by the keep policy |
| res_valid | output | 1 | One-cycle pulse marking a new result |
| res_data | output | 64 | Registered lookup result |

## Verification
Identity and reversed index patterns over a full table show that each lane takes its own index and that byte numbering runs from the low end. Indices that sit exactly on the last valid byte and on the first invalid byte are tried for every word count. These show that the limit follows the count and that bytes past the limit are never used. The same out-of-range vectors are applied under both policies with a recognisable destination pattern, which separates forcing zero from keeping the lane. Indices from 32 to 255, together with mixed lanes and back-to-back requests, show that the compare is unsigned and eight bits wide, that lanes are independent, and that the output holds between requests.

// File: rtl/tlu_pkg.sv
package tlu_pkg;
  localparam int unsigned LANE_W    = 8;
  localparam int unsigned LANES     = 8;
  localparam int unsigned WORD_W    = 64;
  localparam int unsigned MAX_WORDS = 4;

  typedef logic [LANE_W-1:0] lane_t;

  typedef enum logic {
    POL_ZERO = 1'b0,
    POL_KEEP = 1'b1
  } oor_policy_e;
endpackage

// File: rtl/tlu_limit_calc.sv
module tlu_limit_calc #(
  parameter int unsigned LANE_W    = 8,
  parameter int unsigned WORD_W    = 64,
  parameter int unsigned MAX_WORDS = 4,
  localparam int unsigned CNT_W    = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
  input  logic [CNT_W-1:0]  words_m1,
  output logic [LANE_W-1:0] last_idx
);
  localparam int unsigned BYTES_PER_WORD = WORD_W / LANE_W;

  int unsigned span;

  // Highest valid index: bytes present minus one
  always_comb begin
    span     = (int'(words_m1) + 1) * BYTES_PER_WORD - 1;
    last_idx = LANE_W'(span);
  end
endmodule

// File: rtl/tlu_lane.sv
module tlu_lane #(
  parameter int unsigned LANE_W    = 8,
  parameter int unsigned TBL_BITS  = 256,
  localparam int unsigned TBL_BYTES = TBL_BITS / LANE_W,
  localparam int unsigned SEL_W     = $clog2(TBL_BYTES)
) (
  input  logic [TBL_BITS-1:0] table_bits,
  input  logic [LANE_W-1:0]   idx,
  input  logic [LANE_W-1:0]   last_idx,
  input  logic                keep,
  input  logic [LANE_W-1:0]   old_byte,
  output logic [LANE_W-1:0]   new_byte
);
  logic              in_range;
  logic [SEL_W-1:0]  sel;
  logic [LANE_W-1:0] picked;

  always_comb begin
    in_range = (idx <= last_idx);
    sel      = idx[SEL_W-1:0];
    picked   = table_bits[int'(sel)*LANE_W +: LANE_W];
    if (in_range) begin
      new_byte = picked;
    end else if (keep) begin
      new_byte = old_byte;
    end else begin
      new_byte = '0;
    end
  end
endmodule

// File: rtl/tlu_result_reg.sv
module tlu_result_reg #(
  parameter int unsigned DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [DATA_W-1:0] load_data,
  output logic              valid_q,
  output logic [DATA_W-1:0] data_q
);
  logic [DATA_W-1:0] data_d;
  logic              valid_d;

  always_comb begin
    valid_d = load_en;
    data_d  = data_q;
    if (load_en) begin
      data_d = load_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      data_q  <= '0;
    end else begin
      valid_q <= valid_d;
      data_q  <= data_d;
    end
  end

  AST_PULSE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> valid_q);  // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> !valid_q);  // R2
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !load_en |=> $stable(data_q));  // R9
endmodule

// File: rtl/byte_table_lookup_unit.sv
module byte_table_lookup_unit #(
  parameter int unsigned LANE_W    = tlu_pkg::LANE_W,
  parameter int unsigned LANES     = tlu_pkg::LANES,
  parameter int unsigned WORD_W    = tlu_pkg::WORD_W,
  parameter int unsigned MAX_WORDS = tlu_pkg::MAX_WORDS,
  localparam int unsigned VEC_W    = LANES * LANE_W,
  localparam int unsigned TBL_BITS = MAX_WORDS * WORD_W,
  localparam int unsigned CNT_W    = (MAX_WORDS > 1) ? $clog2(MAX_WORDS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_keep,
  input  logic [CNT_W-1:0]    req_words_m1,
  input  logic [TBL_BITS-1:0] req_table,
  input  logic [VEC_W-1:0]    req_idx,
  input  logic [VEC_W-1:0]    req_dest,
  output logic                res_valid,
  output logic [VEC_W-1:0]    res_data
);
  localparam int unsigned TBL_BYTES = TBL_BITS / LANE_W;

  logic [LANE_W-1:0] last_idx;
  logic [VEC_W-1:0]  lane_result;

  tlu_limit_calc #(
    .LANE_W   (LANE_W),
    .WORD_W   (WORD_W),
    .MAX_WORDS(MAX_WORDS)
  ) u_limit (
    .words_m1(req_words_m1),
    .last_idx(last_idx)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    tlu_lane #(
      .LANE_W  (LANE_W),
      .TBL_BITS(TBL_BITS)
    ) u_lane (
      .table_bits(req_table),
      .idx       (req_idx[g*LANE_W +: LANE_W]),
      .last_idx  (last_idx),
      .keep      (req_keep),
      .old_byte  (req_dest[g*LANE_W +: LANE_W]),
      .new_byte  (lane_result[g*LANE_W +: LANE_W])
    );

    logic [LANE_W-1:0] a_idx;
    logic              a_oor;
    assign a_idx = req_idx[g*LANE_W +: LANE_W];
    assign a_oor = (int'(a_idx) >= (int'(req_words_m1) + 1) * (WORD_W / LANE_W));

    AST_ZERO_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && a_oor && !req_keep) |=> (res_data[g*LANE_W +: LANE_W] == '0));  // R6
    AST_KEEP_POLICY: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && a_oor && req_keep)
        |=> (res_data[g*LANE_W +: LANE_W] == $past(req_dest[g*LANE_W +: LANE_W])));  // R7
    AST_HIGH_IDX_OOR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && (int'(a_idx) >= TBL_BYTES) && !req_keep)
        |=> (res_data[g*LANE_W +: LANE_W] == '0));  // R8
  end

  tlu_result_reg #(
    .DATA_W(VEC_W)
  ) u_result (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_en  (req_valid),
    .load_data(lane_result),
    .valid_q  (res_valid),
    .data_q   (res_data)
  );

  AST_RESET_CLEAN: assert property (@(posedge clk)
    !rst_n |=> (!res_valid || $past(req_valid)));  // R1
endmodule

// File: tb/byte_table_lookup_unit_tb.sv
`timescale 1ns/1ps
module byte_table_lookup_unit_tb;
  logic         clk;
  logic         rst_n;
  logic         req_valid;
  logic         req_keep;
  logic [1:0]   req_words_m1;
  logic [255:0] req_table;
  logic [63:0]  req_idx;
  logic [63:0]  req_dest;
  logic         res_valid;
  logic [63:0]  res_data;

  int n_checks;
  int n_fail;
  bit done;

  byte_table_lookup_unit u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_keep    (req_keep),
    .req_words_m1(req_words_m1),
    .req_table   (req_table),
    .req_idx     (req_idx),
    .req_dest    (req_dest),
    .res_valid   (res_valid),
    .res_data    (res_data)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [63:0] model(input logic [63:0] idx, input logic [255:0] tbl,
                                        input int words, input bit keep,
                                        input logic [63:0] dest);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) begin
      int k;
      k = int'(idx[i*8 +: 8]);
      if (k < words * 8) r[i*8 +: 8] = tbl[k*8 +: 8];
      else if (keep)     r[i*8 +: 8] = dest[i*8 +: 8];
      else               r[i*8 +: 8] = 8'h00;
    end
    return r;
  endfunction

  function automatic logic [255:0] pattern_table(input logic [7:0] seed);
    logic [255:0] t;
    for (int k = 0; k < 32; k++) t[k*8 +: 8] = seed + 8'(k * 7) + 8'h11;
    return t;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // One request; result checked one edge later, then idle cycle checked
  task automatic apply(input string tag, input logic [63:0] idx, input logic [255:0] tbl,
                       input int words, input bit keep, input logic [63:0] dest);
    logic [63:0] exp;
    exp = model(idx, tbl, words, keep, dest);
    req_valid    = 1'b1;
    req_idx      = idx;
    req_table    = tbl;
    req_words_m1 = 2'(words - 1);
    req_keep     = keep;
    req_dest     = dest;
    @(negedge clk);
    check({tag, " valid (R2)"}, 64'(res_valid), 64'd1);
    check(tag, res_data, exp);
    req_valid = 1'b0;
    req_idx   = ~idx;
    req_dest  = ~dest;
    @(negedge clk);
    check({tag, " idle valid (R2)"}, 64'(res_valid), 64'd0);
    check({tag, " hold (R9)"}, res_data, exp);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    req_valid = 1'b0; req_keep = 1'b0; req_words_m1 = '0;
    req_table = '0; req_idx = '0; req_dest = '0;
    repeat (3) @(negedge clk);
    check("R1 valid in reset", 64'(res_valid), 64'd0);
    check("R1 data in reset", res_data, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 valid after release", 64'(res_valid), 64'd0);
    check("R1 data after release", res_data, 64'd0);
  endtask

  task automatic t_lane_order();
    logic [255:0] t;
    t = pattern_table(8'h20);
    apply("R3 identity", 64'h07060504_03020100, t, 4, 1'b0, '0);
    apply("R3 reversed", 64'h00010203_04050607, t, 4, 1'b0, '0);
    apply("R4 top bytes", 64'h1F1E1D1C_1B1A1918, t, 4, 1'b0, '0);
    apply("R3 repeated lane", 64'h05050505_05050505, t, 4, 1'b1, 64'hAAAA_AAAA_AAAA_AAAA);
  endtask

  task automatic t_boundaries();
    logic [255:0] t;
    t = pattern_table(8'h90);
    for (int w = 1; w <= 4; w++) begin
      logic [7:0] last;
      last = 8'(w * 8 - 1);
      apply("R5 last valid byte", {8{last}}, t, w, 1'b0, 64'h5555_5555_5555_5555);
      apply("R5 first invalid zero", {8{last + 8'd1}}, t, w, 1'b0, 64'h5555_5555_5555_5555);
      apply("R7 first invalid keep", {8{last + 8'd1}}, t, w, 1'b1, 64'h8877_6655_4433_2211);
    end
  endtask

  task automatic t_policies();
    logic [255:0] t;
    t = pattern_table(8'h03);
    apply("R6 mixed zero", 64'h0A_14_00_09_1F_10_08_07, t, 2, 1'b0, 64'hFEDC_BA98_7654_3210);
    apply("R7 mixed keep", 64'h0A_14_00_09_1F_10_08_07, t, 2, 1'b1, 64'hFEDC_BA98_7654_3210);
  endtask

  task automatic t_high_indices();
    logic [255:0] t;
    t = pattern_table(8'h41);
    apply("R8 high zero", 64'hFF_80_7F_40_21_20_3F_1F, t, 4, 1'b0, 64'h0102_0304_0506_0708);
    apply("R8 high keep", 64'hFF_80_7F_40_21_20_3F_1F, t, 4, 1'b1, 64'h0102_0304_0506_0708);
  endtask

  task automatic t_back_to_back();
    logic [255:0] t;
    logic [63:0] e1;
    logic [63:0] e2;
    t = pattern_table(8'h77);
    e1 = model(64'h0001_0203_1011_1213, t, 3, 1'b0, '0);
    e2 = model(64'h1819_1A1B_0405_0607, t, 3, 1'b1, 64'hCAFE_F00D_DEAD_BEEF);
    req_valid = 1'b1; req_table = t; req_words_m1 = 2'd2;
    req_idx = 64'h0001_0203_1011_1213; req_keep = 1'b0; req_dest = '0;
    @(negedge clk);
    check("R2 b2b first", res_data, e1);
    req_idx = 64'h1819_1A1B_0405_0607; req_keep = 1'b1; req_dest = 64'hCAFE_F00D_DEAD_BEEF;
    @(negedge clk);
    check("R2 b2b second", res_data, e2);
    check("R2 b2b valid", 64'(res_valid), 64'd1);
    req_valid = 1'b0;
    @(negedge clk);
    check("R2 b2b end", 64'(res_valid), 64'd0);
    check("R9 b2b hold", res_data, e2);
  endtask

  initial begin
    n_checks = 0;
    n_fail = 0;
    done = 1'b0;
    t_reset();
    t_lane_order();
    t_boundaries();
    t_policies();
    t_high_indices();
    t_back_to_back();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule